// File: doc/BRIEF.md
# Boundary Scan Pad Chain

This block is the data register that sits between core logic and the package pads for boundary scan testing. A separate TAP controller and instruction decoder supply the current instruction code and the capture, shift and update strobes. This block supplies the scan cells, the serial chain from TDI to TDO, the update latches and the multiplexers that choose, for each pad, between the core and the scan latches.

The pad set is a parameter, and each pad is one of four kinds: input only, output only, tristate output, or bidirectional. Each pad gets exactly the cells its kind needs, so the chain length is the sum over all pads. Instruction code 0 is the external/internal test function: the update latches drive the pads. Code 2 is the sample/preload function: the chain observes the pins and can be loaded while the pads keep working normally. Every other code leaves the chain alone.

Top module: `bsc_chain`

## Requirements
- R1: Cells per pad kind (2-bit kind code: 0 input, 1 output, 2 tristate output, 3 bidirectional) are 1, 1, 2 and 3. Chain bit 0 is the cell next to TDO and belongs to pad 0. Pads follow in index order, and within a pad the cells run input, output, then enable.
- R2: When the capture strobe arrives under code 0 or 2, each input cell loads the pad input, each output cell loads the core output and each enable cell loads the core output enable.
- R3: When the shift strobe arrives under code 0 or 2, the chain moves one place toward TDO and TDI enters at the far end. tdo_o always shows chain bit 0.
- R4: An update latch loads its cell's chain bit only on the update strobe under code 0 or 2. Capture or shift alone never moves a pad.
- R5: When the code is not 0, or while TAP reset is high, pads pass through: output and tristate/bidirectional pads drive the core output, tristate/bidirectional pads take the core enable, output-only pads are always enabled, and input-only pads drive 0 with enable 0.
- R6: Under code 0 (TAP reset low), output and tristate/bidirectional pads drive their output latch, tristate/bidirectional pads take their enable latch, output-only pads stay enabled, and input-only pads stay at 0 with enable 0.
- R7: core_i_o follows pad_i_i for input and bidirectional pads in every mode, and is 0 for output-only and tristate-output pads.
- R8: Under any code other than 0 or 2, the capture, shift and update strobes have no effect on the chain or the latches.
- R9: A TAP reset clears every chain cell and update latch at the next clock and forces pass-through while it is high.
- R10: The asynchronous reset rst_ni clears every chain cell and update latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Test clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tap_reset_i | input | 1 | TAP in test-logic-reset state |
| instr_i | input | IR_W | Decoded instruction code |
| capture_dr_i | input | 1 | Capture strobe |
| shift_dr_i | input | 1 | Shift strobe |
| update_dr_i | input | 1 | Update strobe |
| tdi_i | input | 1 | Serial data in |
| tdo_o | output | 1 | Serial data out (chain bit 0) |
| core_o_i | input | NUM_PADS | Core output data per pad |
| core_oe_i | input | NUM_PADS | Core output enable per pad |
| core_i_o | output | NUM_PADS | Pad input value presented to the core |
| pad_i_i | input | NUM_PADS | Value received from the pad |
| pad_o_o | output | NUM_PADS | Value driven to the pad |
| pad_oe_o | output | NUM_PADS | Pad output enable |

## Verification
The chain and the latches change at the clock edge that samples a strobe. tdo_o therefore shows the captured or shifted bit one edge after the strobe. Pads driven from the latches show the new value one edge after the update strobe. Pass-through outputs and core_i_o follow the core, the pad and the instruction inputs in the same cycle, with no register between them. The bench drives inputs at the falling edge, moves its own model across the rising edge, and compares tdo_o, the pads and core_i_o at the next falling edge, so every sample sees the settled state after exactly one edge.

// File: rtl/bsc_pkg.sv
package bsc_pkg;
  typedef enum logic [1:0] {
    PAD_IN    = 2'd0,
    PAD_OUT   = 2'd1,
    PAD_TRI   = 2'd2,
    PAD_BIDIR = 2'd3
  } pad_kind_e;

  localparam int unsigned OP_EXTEST = 0;
  localparam int unsigned OP_SAMPLE = 2;

  function automatic int unsigned cell_count(logic [1:0] kind);
    case (kind)
      PAD_TRI:   return 2;
      PAD_BIDIR: return 3;
      default:   return 1;
    endcase
  endfunction
endpackage

// File: rtl/bsc_cell.sv
module bsc_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic cap_en_i,
  input  logic shift_en_i,
  input  logic cap_d_i,
  input  logic si_i,
  output logic so_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         so_o <= 1'b0;
    else if (clr_i)      so_o <= 1'b0;
    else if (cap_en_i)   so_o <= cap_d_i;
    else if (shift_en_i) so_o <= si_i;
  end

  // R2
  cap_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_en_i && !clr_i) |=> (so_o == $past(cap_d_i)));
  // R3
  shift_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_en_i && !cap_en_i && !clr_i) |=> (so_o == $past(si_i)));
  // R9
  cell_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (so_o == 1'b0));
endmodule

// File: rtl/bsc_latch.sv
module bsc_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic upd_en_i,
  input  logic d_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       q_o <= 1'b0;
    else if (clr_i)    q_o <= 1'b0;
    else if (upd_en_i) q_o <= d_i;
  end

  // R4
  upd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!upd_en_i && !clr_i) |=> $stable(q_o));
  // R9
  latch_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (q_o == 1'b0));
endmodule

// File: rtl/bsc_pad_mux.sv
module bsc_pad_mux
  import bsc_pkg::*;
#(
  parameter logic [1:0] KIND = PAD_BIDIR
) (
  input  logic test_i,
  input  logic core_o_i,
  input  logic core_oe_i,
  input  logic upd_out_i,
  input  logic upd_oe_i,
  input  logic pad_i_i,
  output logic pad_o_o,
  output logic pad_oe_o,
  output logic core_i_o
);
  logic unused_mux;
  assign unused_mux = ^{test_i, core_o_i, core_oe_i, upd_out_i, upd_oe_i, pad_i_i};

  if (KIND == PAD_IN) begin : g_in
    assign pad_o_o  = 1'b0;
    assign pad_oe_o = 1'b0;
    assign core_i_o = pad_i_i;
  end else if (KIND == PAD_OUT) begin : g_out
    assign pad_o_o  = test_i ? upd_out_i : core_o_i;
    assign pad_oe_o = 1'b1;
    assign core_i_o = 1'b0;
  end else begin : g_tri
    assign pad_o_o  = test_i ? upd_out_i : core_o_i;
    assign pad_oe_o = test_i ? upd_oe_i  : core_oe_i;
    assign core_i_o = (KIND == PAD_BIDIR) ? pad_i_i : 1'b0;
  end
endmodule

// File: rtl/bsc_chain.sv
module bsc_chain
  import bsc_pkg::*;
#(
  parameter int unsigned NUM_PADS = 4,
  parameter int unsigned IR_W     = 4,
  parameter logic [2*NUM_PADS-1:0] PAD_KINDS = {PAD_BIDIR, PAD_TRI, PAD_OUT, PAD_IN}
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tap_reset_i,
  input  logic [IR_W-1:0]     instr_i,
  input  logic                capture_dr_i,
  input  logic                shift_dr_i,
  input  logic                update_dr_i,
  input  logic                tdi_i,
  output logic                tdo_o,
  input  logic [NUM_PADS-1:0] core_o_i,
  input  logic [NUM_PADS-1:0] core_oe_i,
  output logic [NUM_PADS-1:0] core_i_o,
  input  logic [NUM_PADS-1:0] pad_i_i,
  output logic [NUM_PADS-1:0] pad_o_o,
  output logic [NUM_PADS-1:0] pad_oe_o
);
  function automatic int unsigned pad_off(int unsigned p);
    int unsigned s = 0;
    for (int unsigned q = 0; q < p; q++) s += cell_count(PAD_KINDS[2*q +: 2]);
    return s;
  endfunction

  // sel: 0 in, 1 drives output, 2 has enable cell, 3 output-only
  function automatic logic [NUM_PADS-1:0] kind_mask(int unsigned sel);
    logic [NUM_PADS-1:0] m = '0;
    for (int unsigned q = 0; q < NUM_PADS; q++) begin
      logic [1:0] k = PAD_KINDS[2*q +: 2];
      case (sel)
        0:       m[q] = (k == PAD_IN) || (k == PAD_BIDIR);
        1:       m[q] = (k != PAD_IN);
        2:       m[q] = (k == PAD_TRI) || (k == PAD_BIDIR);
        default: m[q] = (k == PAD_OUT);
      endcase
    end
    return m;
  endfunction

  localparam int unsigned CHAIN_LEN = pad_off(NUM_PADS);
  localparam logic [NUM_PADS-1:0] IN_MASK  = kind_mask(0);
  localparam logic [NUM_PADS-1:0] DRV_MASK = kind_mask(1);
  localparam logic [NUM_PADS-1:0] OE_MASK  = kind_mask(2);
  localparam logic [NUM_PADS-1:0] FIX_MASK = kind_mask(3);

  logic sel, test_mode, cap_en, shift_en, upd_en;
  logic [CHAIN_LEN:0] sr_w;

  assign sel       = (instr_i == IR_W'(OP_EXTEST)) || (instr_i == IR_W'(OP_SAMPLE));
  assign test_mode = (instr_i == IR_W'(OP_EXTEST)) && !tap_reset_i;
  assign cap_en    = capture_dr_i && sel;
  assign shift_en  = shift_dr_i && sel;
  assign upd_en    = update_dr_i && sel;

  assign sr_w[CHAIN_LEN] = tdi_i;
  assign tdo_o           = sr_w[0];

  for (genvar g = 0; g < NUM_PADS; g++) begin : g_pad
    localparam logic [1:0]  KIND    = PAD_KINDS[2*g +: 2];
    localparam bit          HAS_IN  = (KIND == PAD_IN) || (KIND == PAD_BIDIR);
    localparam bit          HAS_OUT = (KIND != PAD_IN);
    localparam bit          HAS_OE  = (KIND == PAD_TRI) || (KIND == PAD_BIDIR);
    localparam int unsigned OFF     = pad_off(g);
    localparam int unsigned OUT_IX  = OFF + (HAS_IN ? 1 : 0);
    localparam int unsigned OE_IX   = OUT_IX + 1;

    logic upd_out, upd_oe;

    if (HAS_IN) begin : g_in_cell
      bsc_cell u_cell (
        .clk_i, .rst_ni, .clr_i(tap_reset_i), .cap_en_i(cap_en), .shift_en_i(shift_en),
        .cap_d_i(pad_i_i[g]), .si_i(sr_w[OFF+1]), .so_o(sr_w[OFF]));
    end

    if (HAS_OUT) begin : g_out_cell
      bsc_cell u_cell (
        .clk_i, .rst_ni, .clr_i(tap_reset_i), .cap_en_i(cap_en), .shift_en_i(shift_en),
        .cap_d_i(core_o_i[g]), .si_i(sr_w[OUT_IX+1]), .so_o(sr_w[OUT_IX]));
      bsc_latch u_latch (
        .clk_i, .rst_ni, .clr_i(tap_reset_i), .upd_en_i(upd_en),
        .d_i(sr_w[OUT_IX]), .q_o(upd_out));
    end else begin : g_no_out
      assign upd_out = 1'b0;
    end

    if (HAS_OE) begin : g_oe_cell
      bsc_cell u_cell (
        .clk_i, .rst_ni, .clr_i(tap_reset_i), .cap_en_i(cap_en), .shift_en_i(shift_en),
        .cap_d_i(core_oe_i[g]), .si_i(sr_w[OE_IX+1]), .so_o(sr_w[OE_IX]));
      bsc_latch u_latch (
        .clk_i, .rst_ni, .clr_i(tap_reset_i), .upd_en_i(upd_en),
        .d_i(sr_w[OE_IX]), .q_o(upd_oe));
    end else begin : g_no_oe
      assign upd_oe = 1'b0;
    end

    bsc_pad_mux #(.KIND(KIND)) u_mux (
      .test_i(test_mode), .core_o_i(core_o_i[g]), .core_oe_i(core_oe_i[g]),
      .upd_out_i(upd_out), .upd_oe_i(upd_oe), .pad_i_i(pad_i_i[g]),
      .pad_o_o(pad_o_o[g]), .pad_oe_o(pad_oe_o[g]), .core_i_o(core_i_o[g]));
  end

  // R8
  idle_tdo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((capture_dr_i || shift_dr_i) && !sel && !tap_reset_i) |=> $stable(tdo_o));
  // R5
  pass_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !test_mode |-> (pad_o_o == (core_o_i & DRV_MASK)));
  // R5
  pass_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !test_mode |-> (pad_oe_o == ((core_oe_i & OE_MASK) | FIX_MASK)));
  // R7
  core_in_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_i_o == (pad_i_i & IN_MASK));
  // R6
  out_only_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pad_oe_o & FIX_MASK) == FIX_MASK));
endmodule

// File: tb/bsc_chain_test.sv
module bsc_chain_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [6:0] UPD_MASK = 7'b1101110;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tap_rst = 1'b0;
  logic [3:0] instr = 4'd1;
  logic       cap = 1'b0, sh = 1'b0, up = 1'b0, tdi = 1'b0;
  logic       tdo;
  logic [3:0] core_o = '0, core_oe = '0, pad_i = '0;
  logic [3:0] core_i, pad_o, pad_oe;

  logic [6:0] m_sr = '0, m_upd = '0;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bsc_chain uut (
    .clk_i(clk), .rst_ni(rst_ni), .tap_reset_i(tap_rst), .instr_i(instr),
    .capture_dr_i(cap), .shift_dr_i(sh), .update_dr_i(up), .tdi_i(tdi), .tdo_o(tdo),
    .core_o_i(core_o), .core_oe_i(core_oe), .core_i_o(core_i),
    .pad_i_i(pad_i), .pad_o_o(pad_o), .pad_oe_o(pad_oe));

  // R1 bit layout: 0 pad0 in, 1 pad1 out, 2 pad2 out, 3 pad2 oe, 4 pad3 in, 5 pad3 out, 6 pad3 oe
  function automatic logic [6:0] cap_vec();
    return {core_oe[3], core_o[3], pad_i[3], core_oe[2], core_o[2], core_o[1], pad_i[0]};
  endfunction

  function automatic logic test_on();
    return (instr == 4'd0) && !tap_rst;
  endfunction

  function automatic logic [3:0] exp_pad_o();
    if (test_on()) return {m_upd[5], m_upd[2], m_upd[1], 1'b0};
    return {core_o[3:1], 1'b0};
  endfunction

  function automatic logic [3:0] exp_pad_oe();
    if (test_on()) return {m_upd[6], m_upd[3], 1'b1, 1'b0};
    return {core_oe[3], core_oe[2], 1'b1, 1'b0};
  endfunction

  task automatic chk(input string tag, input string what, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, got, exp, $time);
    end
  endtask

  task automatic check_all(input string tag);
    chk(tag, "tdo", {7'd0, tdo}, {7'd0, m_sr[0]});
    chk(tag, "pad_o", {4'd0, pad_o}, {4'd0, exp_pad_o()});
    chk(tag, "pad_oe", {4'd0, pad_oe}, {4'd0, exp_pad_oe()});
    chk("R7", "core_i", {4'd0, core_i}, {4'd0, pad_i[3], 2'b00, pad_i[0]});
  endtask

  // called at a falling edge; one rising edge, compare at next falling edge
  task automatic cyc(input logic c, input logic s, input logic u, input logic d, input string tag);
    logic [6:0] old;
    cap = c; sh = s; up = u; tdi = d;
    old = m_sr;
    if (tap_rst) begin
      m_sr = '0; m_upd = '0;
    end else if (instr == 4'd0 || instr == 4'd2) begin
      if (c)      m_sr = cap_vec();
      else if (s) m_sr = {d, m_sr[6:1]};
      if (u)      m_upd = old & UPD_MASK;
    end
    @(posedge clk);
    @(negedge clk);
    check_all(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [6:0] word;
    logic [6:0] pat;
    string tag;
    void'($urandom(32'd1234));
    // R10: async reset state
    pad_i = 4'b1001; core_o = 4'b0110; core_oe = 4'b1100;
    #(CLK_PERIOD*2 + 1);
    @(negedge clk);
    check_all("R10");
    rst_ni = 1'b1;
    cyc(0, 0, 0, 0, "R5");

    // R1, R2: capture a known pattern and read it out
    instr = 4'd2;
    pad_i = 4'b1001; core_o = 4'b1010; core_oe = 4'b0100;
    cyc(1, 0, 0, 0, "R2");
    word = '0;
    word[0] = tdo;
    for (int i = 1; i < 7; i++) begin
      cyc(0, 1, 0, 0, "R3");
      word[i] = tdo;
    end
    chk("R1", "captured word", {1'b0, word}, {1'b0, 7'b0111011});

    // R4: preload under code 2, pads keep passing through while shifting
    pat = 7'b1101010;
    for (int i = 0; i < 7; i++) cyc(0, 1, 0, pat[i], "R4");
    cyc(0, 0, 1, 0, "R4");
    core_o = 4'b0101; core_oe = 4'b0001;
    instr = 4'd0;
    @(negedge clk);
    check_all("R6");
    chk("R6", "preloaded pad_o", {4'd0, pad_o}, 8'h0A);
    chk("R6", "preloaded pad_oe", {4'd0, pad_oe}, 8'h0E);
    // R4: shifting under test code leaves pads still
    for (int i = 0; i < 7; i++) cyc(0, 1, 0, 1'b0, "R4");
    chk("R4", "pad_o after shift", {4'd0, pad_o}, 8'h0A);
    cyc(0, 0, 1, 0, "R4");
    chk("R4", "pad_o after update", {4'd0, pad_o}, 8'h00);

    // R8: other code ignores strobes
    instr = 4'd1;
    cyc(1, 0, 0, 0, "R8");
    cyc(0, 1, 1, 1, "R8");
    cyc(0, 1, 1, 1, "R8");

    // R9: TAP reset from a loaded test state
    instr = 4'd2;
    for (int i = 0; i < 7; i++) cyc(0, 1, 0, 1'b1, "R3");
    cyc(0, 0, 1, 0, "R4");
    instr = 4'd0;
    tap_rst = 1'b1;
    @(negedge clk);
    chk("R9", "pass-through during reset", {4'd0, pad_o}, {4'd0, core_o[3:1], 1'b0});
    cyc(0, 0, 0, 0, "R9");
    tap_rst = 1'b0;
    @(negedge clk);
    check_all("R9");
    chk("R9", "cleared latches pad_oe", {4'd0, pad_oe}, 8'h02);
    instr = 4'd3;
    cyc(0, 0, 0, 0, "R5");

    // R10: async reset clears latches loaded under test code
    instr = 4'd2;
    for (int i = 0; i < 7; i++) cyc(0, 1, 0, 1'b1, "R3");
    cyc(0, 0, 1, 0, "R4");
    instr = 4'd0;
    rst_ni = 1'b0;
    m_sr = '0; m_upd = '0;
    #1;
    chk("R10", "pad_oe after async reset", {4'd0, pad_oe}, 8'h02);
    @(negedge clk);
    rst_ni = 1'b1;
    cyc(0, 0, 0, 0, "R10");

    // random mix
    for (int n = 0; n < 600; n++) begin
      int r;
      logic c, s, u;
      if (n % 16 == 0) instr = 4'($urandom % 4);
      pad_i = 4'($urandom); core_o = 4'($urandom); core_oe = 4'($urandom);
      tap_rst = ($urandom % 40) == 0;
      r = $urandom % 8;
      c = (r == 0); s = (r >= 1 && r <= 4); u = (r == 5) || (r == 6);
      if (tap_rst) tag = "R9";
      else if (instr != 0 && instr != 2 && (c || s || u)) tag = "R8";
      else if (c) tag = "R2";
      else if (s) tag = "R3";
      else if (instr == 0) tag = "R6";
      else tag = "R5";
      cyc(c, s, u, 1'($urandom), tag);
    end
    tap_rst = 1'b0;

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule